// File: doc/BRIEF.md
# Sub-Clock Interval Timer

This block counts ticks of a slow sub-clock in a 15-bit free-running counter and raises an interrupt at a software-chosen interval. The sub-clock is delivered as a one-cycle enable, `sub_tick_i`, in the system clock domain at 8.192 kHz. The oscillator and any clock-domain crossing sit outside the block. The counter keeps running whenever ticks arrive, so the timer keeps working while the rest of the chip sleeps on the sub-clock alone.

A 3-bit code picks one of seven power-of-two intervals, from 256 ticks (31.25 ms) up to 16384 ticks (2 s). When the counter carries out of the selected bit, an event flag sets. The flag stays set until software writes a one to clear it. The interrupt request is the flag gated by an enable.

Software can also zero the counter, which restarts the interval from its beginning. Bit 14 of the counter is brought out as a slow square wave that other timers can use. The interface has no data stream, so every pin is a plain control or status level.

Top module: `wt_watch_timer`

## Requirements
- R1: While `rst_ni` is low, the counter is zero and `flag_o`, `irq_o` and `tap_o` are all 0.
- R2: The counter advances by exactly one on each clock edge where `sub_tick_i` is 1 and `cnt_clr_i` is 0. It holds its value on every other edge, and after reaching 32767 it wraps to 0.
- R3: With select code c in 0..6, counter bit 7+c is the selected bit and the interval is 2^(8+c) ticks. `flag_o` sets on the edge where the counter passes from 2^(8+c)·k − 1 to 2^(8+c)·k, which is the carry out of the selected bit. After a counter clear, the first set therefore comes exactly 2^(8+c) ticks later.
- R4: Select code 7 is reserved. With it, `flag_o` never sets.
- R5: Once set, `flag_o` holds until a cycle with `flag_w1c_i` = 1. When no new event arrives in that cycle, `flag_o` is 0 from the next edge on.
- R6: If an interval event and `flag_w1c_i` fall on the same edge, the event wins and `flag_o` is 1 afterwards.
- R7: `irq_o` is `flag_o` AND `irq_en_i`. `irq_en_i` never changes `flag_o`.
- R8: `cnt_clr_i` = 1 zeroes the counter on that edge, even if a tick arrives on the same edge. It leaves `flag_o` untouched, and no event is raised on a clearing edge.
- R9: Changing `ivl_sel_i` does not clear the counter. A newly selected bit that is already 1 does not set the flag. The next set comes at that bit's next carry.
- R10: `tap_o` equals counter bit 14. It first rises 16384 ticks after a counter clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sub_tick_i | input | 1 | One-cycle enable, one per sub-clock period |
| ivl_sel_i | input | 3 | Interval code: 0..6 selects 2^8..2^14 ticks, 7 is reserved |
| irq_en_i | input | 1 | Interrupt enable |
| flag_w1c_i | input | 1 | Pulse for a software write of 1 that clears the flag |
| cnt_clr_i | input | 1 | Zeroes the counter |
| irq_o | output | 1 | Interrupt request |
| flag_o | output | 1 | Interval event flag |
| tap_o | output | 1 | Counter bit 14, for other timers |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a carry from the selected bit and a software clear of the flag. The bench provokes it by counting exactly 255 ticks after a counter clear with code 0, then raising `flag_w1c_i` for the edge on which tick 256 lands. The flag must read 1 afterwards. The second pair is a tick and a counter clear on the same edge. The bench holds the clear across ticking cycles and then confirms that the next event arrives a full interval after the release, not earlier.

// File: rtl/wt_pkg.sv
package wt_pkg;
  localparam int unsigned WT_CNT_W     = 15;
  localparam int unsigned WT_SEL_W     = 3;
  localparam int unsigned WT_BASE_BIT  = 7;
  localparam int unsigned WT_NUM_CODES = 7;
  localparam int unsigned WT_TAP_BIT   = 14;

  typedef logic [WT_SEL_W-1:0] wt_sel_t;
endpackage

// File: rtl/wt_counter.sv
module wt_counter #(
  parameter int unsigned CNT_W     = wt_pkg::WT_CNT_W,
  parameter int unsigned BASE_BIT  = wt_pkg::WT_BASE_BIT,
  parameter int unsigned NUM_CODES = wt_pkg::WT_NUM_CODES,
  parameter int unsigned TAP_BIT   = wt_pkg::WT_TAP_BIT
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 clr_i,
  output logic [NUM_CODES-1:0] wrap_o,
  output logic                 tap_o
);
  localparam int unsigned CHAIN_W = BASE_BIT + NUM_CODES;
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0]   cnt_q;
  logic [CHAIN_W-1:0] all_ones;
  logic               advance;

  assign advance = tick_i && !clr_i;

  // all_ones[k]: bits k..0 are all set, so the next advance carries out of bit k
  assign all_ones[0] = cnt_q[0];
  for (genvar k = 1; k < CHAIN_W; k++) begin : g_chain
    assign all_ones[k] = all_ones[k-1] & cnt_q[k];
  end

  for (genvar c = 0; c < NUM_CODES; c++) begin : g_wrap
    assign wrap_o[c] = advance & all_ones[BASE_BIT+c];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_q + ONE;
  end

  assign tap_o = cnt_q[TAP_BIT];

  p_clear_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> $stable(cnt_q));
  p_step_one_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !clr_i) |=> (cnt_q == $past(cnt_q) + ONE));
endmodule

// File: rtl/wt_tap_sel.sv
module wt_tap_sel #(
  parameter int unsigned SEL_W     = wt_pkg::WT_SEL_W,
  parameter int unsigned NUM_CODES = wt_pkg::WT_NUM_CODES
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [SEL_W-1:0]     sel_i,
  input  logic [NUM_CODES-1:0] wrap_i,
  output logic                 event_o
);
  logic [NUM_CODES-1:0] hit;

  for (genvar c = 0; c < NUM_CODES; c++) begin : g_code
    assign hit[c] = (sel_i == SEL_W'(c)) && wrap_i[c];
  end

  assign event_o = |hit;

  p_single_hit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit));
  p_reserved_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i >= SEL_W'(NUM_CODES)) |-> !event_o);
endmodule

// File: rtl/wt_flag.sv
module wt_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic en_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;

  // a new event outranks a software clear landing on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & en_i;

  p_set_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);
  p_w1c_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_q);
  p_flag_holds_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !set_i) |=> $stable(flag_q));
endmodule

// File: rtl/wt_watch_timer.sv
module wt_watch_timer #(
  parameter int unsigned CNT_W     = wt_pkg::WT_CNT_W,
  parameter int unsigned SEL_W     = wt_pkg::WT_SEL_W,
  parameter int unsigned BASE_BIT  = wt_pkg::WT_BASE_BIT,
  parameter int unsigned NUM_CODES = wt_pkg::WT_NUM_CODES,
  parameter int unsigned TAP_BIT   = wt_pkg::WT_TAP_BIT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sub_tick_i,
  input  logic [SEL_W-1:0] ivl_sel_i,
  input  logic             irq_en_i,
  input  logic             flag_w1c_i,
  input  logic             cnt_clr_i,
  output logic             irq_o,
  output logic             flag_o,
  output logic             tap_o
);
  logic [NUM_CODES-1:0] wrap;
  logic                 ivl_event;

  wt_counter #(
    .CNT_W(CNT_W), .BASE_BIT(BASE_BIT), .NUM_CODES(NUM_CODES), .TAP_BIT(TAP_BIT)
  ) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(sub_tick_i), .clr_i(cnt_clr_i),
    .wrap_o(wrap), .tap_o(tap_o)
  );

  wt_tap_sel #(.SEL_W(SEL_W), .NUM_CODES(NUM_CODES)) u_sel (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(ivl_sel_i), .wrap_i(wrap),
    .event_o(ivl_event)
  );

  wt_flag u_flag (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(ivl_event), .clr_i(flag_w1c_i),
    .en_i(irq_en_i), .flag_o(flag_o), .irq_o(irq_o)
  );

  p_no_event_on_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_clr_i && !flag_o) |=> !flag_o);
  p_en_keeps_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ivl_event && !flag_w1c_i) |=> (flag_o == $past(flag_o)));
endmodule

// File: tb/wt_watch_timer_test.sv
module wt_watch_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [2:0] sel = 3'd0;
  logic       en = 1'b0;
  logic       w1c = 1'b0;
  logic       cclr = 1'b0;
  logic       irq, flag, tap;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  wt_watch_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .sub_tick_i(tick), .ivl_sel_i(sel),
    .irq_en_i(en), .flag_w1c_i(w1c), .cnt_clr_i(cclr),
    .irq_o(irq), .flag_o(flag), .tap_o(tap)
  );

  // {code, irq enable, log2 of interval (0 = expect no event)}
  localparam logic [7:0] VECS [0:7] = '{
    {3'd0, 1'b1, 4'd8},  {3'd1, 1'b0, 4'd9},  {3'd2, 1'b1, 4'd10},
    {3'd3, 1'b0, 4'd11}, {3'd4, 1'b1, 4'd12}, {3'd5, 1'b1, 4'd13},
    {3'd6, 1'b0, 4'd14}, {3'd7, 1'b1, 4'd0}
  };

  task automatic chk(input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", what, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic restart(input logic [2:0] code);
    sel = code; cclr = 1'b1; w1c = 1'b1; tick = 1'b1;
    @(negedge clk);
    cclr = 1'b0; w1c = 1'b0;
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cycles == 190000) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    ticks(3);
    chk("R1 flag in reset", flag, 1'b0);
    chk("R1 irq in reset", irq, 1'b0);
    chk("R1 tap in reset", tap, 1'b0);
    rst_n = 1'b1;
    ticks(1);
    chk("R1 flag after reset", flag, 1'b0);

    // table: each code timed from a counter clear
    for (int i = 0; i < 8; i++) begin
      logic [2:0] code;
      logic       ie;
      logic [3:0] lg;
      {code, ie, lg} = VECS[i];
      en = ie;
      restart(code);
      if (lg != 4'd0) begin
        ticks((1 << lg) - 1);
        chk($sformatf("R3 code %0d before interval", code), flag, 1'b0);
        ticks(1);
        chk($sformatf("R3 code %0d at interval", code), flag, 1'b1);
        chk($sformatf("R7 irq gate code %0d", code), irq, ie);
      end else begin
        ticks(20000);
        chk("R4 reserved code flag", flag, 1'b0);
        chk("R4 reserved code irq", irq, 1'b0);
      end
    end

    // R7: enabling later exposes the held flag without altering it
    en = 1'b0;
    restart(3'd0);
    ticks(256);
    chk("R7 flag with irq disabled", flag, 1'b1);
    chk("R7 irq disabled", irq, 1'b0);
    en = 1'b1;
    #1;
    chk("R7 irq after enable", irq, 1'b1);

    // R6: software clear on the same edge as the carry
    restart(3'd0);
    ticks(255);
    chk("R6 flag before collision", flag, 1'b0);
    w1c = 1'b1;
    ticks(1);
    w1c = 1'b0;
    chk("R6 event beats clear", flag, 1'b1);

    // R5: hold without ticks, then clear
    tick = 1'b0;
    ticks(20);
    chk("R5 flag holds", flag, 1'b1);
    w1c = 1'b1;
    ticks(1);
    w1c = 1'b0;
    chk("R5 w1c clears", flag, 1'b0);
    tick = 1'b1;

    // R8: counter clear held across ticking edges
    restart(3'd0);
    ticks(200);
    cclr = 1'b1;
    ticks(3);
    cclr = 1'b0;
    ticks(255);
    chk("R8 no early event after clear", flag, 1'b0);
    ticks(1);
    chk("R8 full interval after clear", flag, 1'b1);
    cclr = 1'b1;
    ticks(2);
    cclr = 1'b0;
    chk("R8 clear keeps flag", flag, 1'b1);

    // R2: idle cycles without tick do not count
    restart(3'd0);
    ticks(100);
    tick = 1'b0;
    ticks(1000);
    chk("R2 no count while idle", flag, 1'b0);
    tick = 1'b1;
    ticks(155);
    chk("R2 one short of interval", flag, 1'b0);
    ticks(1);
    chk("R2 interval reached", flag, 1'b1);

    // R9: switch select while the newly chosen bit is already 1
    restart(3'd1);
    ticks(200);
    chk("R9 before switch", flag, 1'b0);
    sel = 3'd0;
    ticks(1);
    chk("R9 no set on level", flag, 1'b0);
    ticks(54);
    chk("R9 before next carry", flag, 1'b0);
    ticks(1);
    chk("R9 set at carry, count kept", flag, 1'b1);

    // R10: tap is counter bit 14
    restart(3'd0);
    ticks(16383);
    chk("R10 tap low", tap, 1'b0);
    ticks(1);
    chk("R10 tap high", tap, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule